// File: doc/BRIEF.md
# Pulse-and-Verify Byte Programming Sequencer

This block writes a run of bytes into a one-time-programmable memory array, one address at a time. A start command loads a first address and a byte count. The data bytes then come in over a valid/ready stream. For each byte the sequencer puts the address and data on the memory bus and waits one cycle for them to settle. It then drops chip enable for a programming pulse of a fixed number of clock cycles. After one idle cycle it reads the byte back with output enable low and chip enable high. If the read-back matches, it moves on to the next address at once. If it does not match, it pulses again, up to a fixed number of attempts.

The memory's erased state is all ones, so only zero bits need programming. A byte whose target is all ones is accepted and skipped with no pulse at all. A byte that still fails to match after the last permitted pulse ends the whole block. The sequencer records the failing address, raises a fail flag and takes no further bytes. The programming-supply flag is high for as long as a block is in progress. A single-cycle done strobe, together with a pass flag, marks the end of every block.

Top module: `otp_burn_sequencer`

## Requirements
- R1: After reset, chip enable and output enable are high (inactive), the supply flag, done, pass, fail and the stream ready are low.
- R2: Every programming pulse holds chip enable low for exactly PULSE_CYC consecutive clock cycles.
- R3: Pulsing of a byte stops on the first verify that matches. The attempt count restarts at zero for every new address, so a byte needing k pulses receives exactly k.
- R4: A byte receives at most MAX_TRIES pulses. A byte that first matches after pulse number MAX_TRIES still passes.
- R5: If a byte does not match after MAX_TRIES pulses, the block ends with done high, pass low and fail high. fail_addr holds that byte's address and no further stream bytes are accepted.
- R6: A byte equal to all ones is accepted and skipped without any programming pulse.
- R7: Address and data are unchanged for at least one cycle before chip enable falls and while it is low. At least one cycle with both enables high separates the end of a pulse from the verify read.
- R8: Verify drives output enable low with chip enable high. Chip enable and output enable are never low together.
- R9: done is high for exactly one cycle at the end of a block, with pass high when every byte matched.
- R10: A start with a byte count of zero yields the done strobe with pass high on the next cycle, with no pulse and no stream transfer.
- R11: Bytes are written to consecutive addresses, beginning at the start address.
- R12: The supply flag is high whenever either enable is low and is low once the block has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block (accepted while idle) |
| base_addr | input | ADDR_W | First address of the block |
| byte_cnt | input | CNT_W | Number of bytes in the block |
| src_valid | input | 1 | Stream byte available |
| src_data | input | DATA_W | Stream byte value |
| src_ready | output | 1 | Sequencer takes the stream byte this cycle |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_wdata | output | DATA_W | Data driven toward the memory |
| mem_rdata | input | DATA_W | Data read back from the memory |
| mem_ce_n | output | 1 | Chip enable, active low (programming pulse) |
| mem_oe_n | output | 1 | Output enable, active low (verify read) |
| mem_vpp | output | 1 | Programming supply request |
| done | output | 1 | One-cycle end-of-block strobe |
| pass | output | 1 | Whole block matched (valid with done, held after) |
| fail | output | 1 | Block aborted on a byte over the retry limit |
| fail_addr | output | ADDR_W | Address of the byte that failed |

## Verification
Each attempt on a byte is scheduled relative to the cycle in which the stream byte is accepted. Chip enable falls two clock edges later, after the settling cycle, stays low for PULSE_CYC cycles, and is followed by one cycle with both enables high and then one verify cycle. done rises one edge after the deciding verify, or after the acceptance of a final all-ones byte. The bench's memory model applies a pulse's effect on the edge that ends the idle cycle, so the read in the verify cycle sees it. All outputs are sampled on the falling clock edge. Each scenario waits for the done strobe and then idles a few more cycles, so that a second strobe or a stray pulse would still be counted.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_VERIFY
    } burn_state_e;

endpackage

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
    parameter int PULSE_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(PULSE_CYC + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = run ? cnt_q + 1'b1 : '0;
        expire = run && (cnt_q == TW'(PULSE_CYC - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/otp_try_counter.sv
module otp_try_counter #(
    parameter int MAX_TRIES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int NW = $clog2(MAX_TRIES + 1);

    logic [NW-1:0] n_d, n_q;

    always_comb begin
        n_d = n_q;
        if (clr)      n_d = '0;
        else if (inc) n_d = n_q + 1'b1;
        exhausted = (n_q == NW'(MAX_TRIES));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end
endmodule

// File: rtl/otp_burn_sequencer.sv
module otp_burn_sequencer
    import otp_burn_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 16,
    parameter int PULSE_CYC = 5000,
    parameter int MAX_TRIES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_vpp,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam logic [DATA_W-1:0] ERASED = '1;

    typedef struct packed {
        burn_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  remain;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              pass;
        logic              fail;
        logic [ADDR_W-1:0] fail_addr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic pulse_run, pulse_end;
    logic try_clr, try_inc, tries_out;
    logic advance;

    otp_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (pulse_run),
        .expire (pulse_end)
    );

    otp_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (try_clr),
        .inc       (try_inc),
        .exhausted (tries_out)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        advance   = 1'b0;
        pulse_run = (r_q.state == ST_PULSE);
        try_clr   = 1'b0;
        try_inc   = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.fail = 1'b0;
                    r_d.pass = 1'b0;
                    if (byte_cnt == '0) begin
                        r_d.done = 1'b1;
                        r_d.pass = 1'b1;
                    end else begin
                        r_d.addr   = base_addr;
                        r_d.remain = byte_cnt;
                        r_d.state  = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (src_valid) begin
                    r_d.data = src_data;
                    try_clr  = 1'b1;
                    if (src_data == ERASED) advance   = 1'b1;
                    else                    r_d.state = ST_SETUP;
                end
            end
            ST_SETUP: r_d.state = ST_PULSE;
            ST_PULSE: begin
                if (pulse_end) begin
                    try_inc   = 1'b1;
                    r_d.state = ST_HOLD;
                end
            end
            ST_HOLD: r_d.state = ST_VERIFY;
            ST_VERIFY: begin
                if (mem_rdata == r_q.data) begin
                    advance = 1'b1;
                end else if (tries_out) begin
                    r_d.state     = ST_IDLE;
                    r_d.done      = 1'b1;
                    r_d.pass      = 1'b0;
                    r_d.fail      = 1'b1;
                    r_d.fail_addr = r_q.addr;
                end else begin
                    r_d.state = ST_SETUP;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (advance) begin
            if (r_q.remain == CNT_W'(1)) begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.pass  = 1'b1;
            end else begin
                r_d.remain = r_q.remain - 1'b1;
                r_d.addr   = r_q.addr + 1'b1;
                r_d.state  = ST_FETCH;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign src_ready = (r_q.state == ST_FETCH);
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.data;
    assign mem_ce_n  = (r_q.state != ST_PULSE);
    assign mem_oe_n  = (r_q.state != ST_VERIFY);
    assign mem_vpp   = (r_q.state != ST_IDLE);
    assign done      = r_q.done;
    assign pass      = r_q.pass;
    assign fail      = r_q.fail;
    assign fail_addr = r_q.fail_addr;
endmodule

// File: rtl/otp_burn_checker.sv
module otp_burn_checker #(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int PULSE_CYC = 5000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_vpp,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              done,
    input logic              pass,
    input logic              fail
);
    logic [31:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_cnt_q <= '0;
        else if (!mem_ce_n) low_cnt_q <= low_cnt_q + 1'b1;
        else               low_cnt_q <= '0;
    end

    assert_pulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> (low_cnt_q == 32'(PULSE_CYC)));

    assert_setup_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    assert_pulse_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> ($stable(mem_addr) && $stable(mem_wdata)));

    assert_gap_before_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |=> mem_oe_n);

    assert_enables_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_ce_n && !mem_oe_n));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fail_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> fail);

    assert_supply_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n || !mem_oe_n) |-> mem_vpp);
endmodule

bind otp_burn_sequencer otp_burn_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_vpp(mem_vpp), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(done), .pass(pass), .fail(fail)
);

// File: tb/otp_burn_sequencer_test.sv
`timescale 1ns/1ps
module otp_burn_sequencer_test;
    localparam int AW = 15, DW = 8, CW = 8, PC = 6, MT = 10;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [CW-1:0] byte_cnt = '0;
    logic src_valid, src_ready;
    logic [DW-1:0] src_data, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr, fail_addr;
    logic mem_ce_n, mem_oe_n, mem_vpp, done, pass, fail;

    always #10 clk = ~clk;   // 50 MHz

    otp_burn_sequencer #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW),
                         .PULSE_CYC(PC), .MAX_TRIES(MT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .byte_cnt(byte_cnt), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_vpp(mem_vpp), .done(done), .pass(pass), .fail(fail),
        .fail_addr(fail_addr));

    int checks = 0, failures = 0;

    // memory model: a cell takes its programmed value after need[] pulses
    logic [DW-1:0] cells [16];
    int need [16];
    int hits [16];
    logic [DW-1:0] stream [8];
    int nbytes = 0, taken = 0;
    int pulses = 0, min_w = 0, max_w = 0, cur_w = 0;
    int done_cnt = 0, verify_cyc = 0, viol_stable = 0, viol_gap = 0;
    int viol_both = 0, viol_vpp = 0;
    logic done_pass, done_fail;
    logic [AW-1:0] done_faddr;
    logic prev_ce = 1'b1;
    logic [AW-1:0] prev_addr;
    logic [DW-1:0] prev_wdata;

    assign mem_rdata = !mem_oe_n ? cells[mem_addr[3:0]] : '1;

    always @(negedge clk) begin
        src_valid = (taken < nbytes);
        src_data  = stream[taken[2:0]];
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (src_ready && src_valid) taken <= taken + 1;
            if (!mem_ce_n) cur_w = cur_w + 1;
            if (mem_ce_n && !prev_ce) begin
                pulses = pulses + 1;
                hits[mem_addr[3:0]] = hits[mem_addr[3:0]] + 1;
                if (hits[mem_addr[3:0]] >= need[mem_addr[3:0]])
                    cells[mem_addr[3:0]] = cells[mem_addr[3:0]] & mem_wdata;
                if (min_w == 0 || cur_w < min_w) min_w = cur_w;
                if (cur_w > max_w) max_w = cur_w;
                cur_w = 0;
            end
            if (!mem_ce_n && prev_ce && (mem_addr != prev_addr || mem_wdata != prev_wdata))
                viol_stable++;
            if (!mem_oe_n && !prev_ce) viol_gap++;
            if (!mem_oe_n && !mem_ce_n) viol_both++;
            if ((!mem_oe_n || !mem_ce_n) && !mem_vpp) viol_vpp++;
            if (!mem_oe_n) verify_cyc++;
            if (done) begin
                done_cnt++;
                done_pass = pass; done_fail = fail; done_faddr = fail_addr;
            end
            prev_ce = mem_ce_n; prev_addr = mem_addr; prev_wdata = mem_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 16; i++) begin
            cells[i] = '1; need[i] = 1; hits[i] = 0;
        end
        pulses = 0; min_w = 0; max_w = 0; cur_w = 0; done_cnt = 0;
        verify_cyc = 0; taken = 0; nbytes = 0;
    endtask

    task automatic run_block(input int base, input int n);
        @(negedge clk);
        base_addr = AW'(base); byte_cnt = CW'(n); nbytes = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 4000 && done_cnt == 0; t++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        check(mem_ce_n == 1 && mem_oe_n == 1, "R1 enables", {mem_ce_n, mem_oe_n}, 3);
        check(!mem_vpp && !done && !pass && !fail && !src_ready, "R1 flags",
              {mem_vpp, done, pass, fail, src_ready}, 0);
    endtask

    task automatic t_single();
        model_clear(); stream[0] = 8'hA5; need[3] = 1;
        run_block(3, 1);
        check(pulses == 1, "R3 single pulse count", pulses, 1);
        check(min_w == PC && max_w == PC, "R2 pulse width", max_w, PC);
        check(cells[3] == 8'hA5, "R3 programmed value", cells[3], 8'hA5);
        check(done_cnt == 1 && done_pass && !done_fail, "R9 done strobe", done_cnt, 1);
        check(verify_cyc == 1, "R8 verify cycles", verify_cyc, 1);
    endtask

    task automatic t_multi();
        model_clear();
        stream[0] = 8'h12; stream[1] = 8'hFF; stream[2] = 8'h3C;
        need[5] = 3; need[7] = 2;
        run_block(5, 3);
        check(pulses == 5, "R3 retry pulses", pulses, 5);
        check(hits[7] == 2, "R3 per-address count", hits[7], 2);
        check(hits[6] == 0 && cells[6] == 8'hFF, "R6 all-ones skipped", hits[6], 0);
        check(cells[5] == 8'h12 && cells[7] == 8'h3C, "R11 consecutive addresses",
              cells[7], 8'h3C);
        check(done_pass && done_cnt == 1, "R9 pass on block", done_cnt, 1);
    endtask

    task automatic t_limit();
        model_clear(); stream[0] = 8'h00; need[9] = MT;
        run_block(9, 1);
        check(pulses == MT && done_pass, "R4 passes on last try", pulses, MT);
        check(cells[9] == 8'h00, "R4 value", cells[9], 0);
    endtask

    task automatic t_fail();
        model_clear(); stream[0] = 8'h81; stream[1] = 8'h55; need[10] = MT + 1;
        run_block(10, 2);
        check(pulses == MT, "R4 pulse cap", pulses, MT);
        check(done_cnt == 1 && !done_pass && done_fail, "R5 fail flags",
              {done_pass, done_fail}, 1);
        check(done_faddr == 10, "R5 failing address", done_faddr, 10);
        check(taken == 1 && cells[11] == 8'hFF, "R5 rest aborted", taken, 1);
        check(!mem_vpp, "R12 supply off after end", mem_vpp, 0);
    endtask

    task automatic t_zero();
        model_clear();
        run_block(2, 0);
        check(done_cnt == 1 && done_pass, "R10 zero count done", done_cnt, 1);
        check(pulses == 0 && taken == 0, "R10 no activity", pulses + taken, 0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_limit();
        t_fail();
        t_zero();
        check(viol_stable == 0, "R7 stable before pulse", viol_stable, 0);
        check(viol_gap == 0, "R7 gap before read", viol_gap, 0);
        check(viol_both == 0, "R8 enables exclusive", viol_both, 0);
        check(viol_vpp == 0, "R12 supply during access", viol_vpp, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule